// File: doc/BRIEF.md
# Rotate-Mask-Merge Shift Unit

This block is the 32-bit shift datapath of a processor execute stage. From one rotator and two masks it produces left and right logical shifts, arithmetic right shifts, bit-field extracts and bit-field inserts. The caller presents an instruction word together with the operand values that the register file has already read. The block decodes the word into controls, rotates the source, and builds a composite mask. It then forms the result in one of three fill styles: zero fill, merge with the old destination value, or sign-style fill.

The instruction word comes in one of two forms. In the immediate form, the rotate amount and the end-mask count are taken from the word itself. In the register form, the rotate amount comes from a rotate register. When the end-mask field is nonzero, the end-mask count comes from the register that pairs with the source register. A strobe on `in_valid` captures the operands. The result, the destination index and an error flag are registered and appear one clock later with `out_valid`.

An output state machine controls presentation. It has two states. `ST_IDLE` means no result is held as fresh. `ST_SHOW` means a result is presented on this cycle. There are four transitions: `T_CAPTURE` (ST_IDLE to ST_SHOW on a strobe), `T_RELOAD` (ST_SHOW to ST_SHOW on a back-to-back strobe), `T_DRAIN` (ST_SHOW to ST_IDLE with no strobe) and `T_WAIT` (ST_IDLE to ST_IDLE with no strobe).

Top module: `shu_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls when no strobe is given, `out_valid`, `out_result`, `out_err` and `out_dest` are all zero.
- R2: A strobe on `in_valid` produces `out_valid` high on the next clock edge, carrying that strobe's result. Without a strobe, `out_valid` is low after the next edge.
- R3: Direction flag (bit 10) clear rotates the source left by the rotate amount. Direction flag set rotates it right by the amount.
- R4: An end-mask count of 0 gives an all-ones end mask. A count N from 1 to 31 gives the low N bits set. The invert flag (bit 11) complements the end mask.
- R5: The effective amount equals the rotate amount for a left rotation, and equals (32 - amount) mod 32 for a right rotation. For merge codes 0 to 2 the shift mask is all ones. For codes 3 to 5 it holds the low effective-amount bits set. For codes 6 and 7 it is the complement of that. An effective amount of 0 gives a low mask of zero.
- R6: For merge codes 0, 3 and 6, the result is the rotated value ANDed with the composite mask, which is the shift mask ANDed with the end mask.
- R7: For merge codes 1, 4 and 7, result bits inside the composite mask come from the rotated value, and the other bits come from `dest_val`.
- R8: For merge codes 2 and 5, bit 0 of the result is rotated[0] AND mask[0]. Each higher bit b outside the composite mask copies final result bit b-1.
- R9: The immediate form has bits 21:18 = 0001, with the merge code in bits 17:15. The register form has bits 21:16 = 110001, with the merge code in bits 15:13. In both forms, bits 9:5 hold the end-mask field and bits 4:0 hold the rotate field or rotate register index.
- R10: In the register form, the rotate amount is `rot_reg_val[4:0]`. The end-mask count is 0 when field 9:5 is zero, and `pair_val[4:0]` otherwise.
- R11: `out_err` is set, with `out_result` forced to zero, for a word that matches neither form. It is also set for a register-form word with a nonzero end-mask field and an odd source index (bit 22 set).
- R12: `out_dest` carries bits 31:27 of the captured instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand capture strobe |
| instr | input | 32 | Instruction word to decode |
| src_val | input | 32 | Value of the source register |
| pair_val | input | 32 | Value of the register after the source (end-mask count, register form) |
| rot_reg_val | input | 32 | Value of the rotate register (register form) |
| dest_val | input | 32 | Current destination value, used by merge fill |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Shift result |
| out_dest | output | 5 | Destination register index |
| out_err | output | 1 | Illegal operand or unknown encoding |

## Verification
A new strobe can arrive in the same cycle that the previous result is being presented. In that cycle the machine takes `T_RELOAD`, and the result register must take the new value without the old one leaking into it. The vector table is walked with strobes back to back, so every row after the first lands in this case. An error row directly follows a valid one, and each row's output is judged against its own expected value and error flag. A run of random immediate-form words, also issued back to back, is compared against a bit-serial reference model in the bench.

// File: rtl/shu_pkg.sv
package shu_pkg;
    localparam int DW = 32;
    localparam int AW = $clog2(DW);
    localparam int RW = 5;
    localparam int MW = 3;

    typedef enum logic [1:0] {
        FILL_ZERO,
        FILL_MERGE,
        FILL_SIGN
    } fill_e;

    typedef enum logic [1:0] {
        SM_OFF,
        SM_LOW,
        SM_HIGH
    } smask_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } ostate_e;

    typedef struct packed {
        logic [RW-1:0] dest;
        logic [MW-1:0] merge;
        logic          inv;
        logic          dir;
        logic [AW-1:0] emask;
        logic [AW-1:0] amt;
        logic          err;
    } ctl_t;

    function automatic logic [DW-1:0] low_ones(input logic [AW-1:0] n);
        logic [DW-1:0] m;
        for (int b = 0; b < DW; b++) begin
            m[b] = (b < int'(n));
        end
        return m;
    endfunction
endpackage

// File: rtl/shu_decode.sv
module shu_decode
    import shu_pkg::*;
(
    input  logic [DW-1:0] instr,
    input  logic [DW-1:0] rot_reg_val,
    input  logic [DW-1:0] pair_val,
    output ctl_t          ctl
);
    localparam logic [3:0] IMM_OP = 4'b0001;
    localparam logic [5:0] REG_OP = 6'b110001;

    logic imm_hit;
    logic reg_hit;
    logic em_field_nz;

    always_comb begin
        imm_hit     = (instr[21:18] == IMM_OP);
        reg_hit     = (instr[21:16] == REG_OP);
        em_field_nz = (instr[9:5] != '0);

        ctl.dest = instr[31:27];
        ctl.inv  = instr[11];
        ctl.dir  = instr[10];

        if (reg_hit) begin
            ctl.merge = instr[15:13];
            ctl.amt   = rot_reg_val[AW-1:0];
            ctl.emask = em_field_nz ? pair_val[AW-1:0] : '0;
            ctl.err   = em_field_nz && instr[22];
        end else begin
            ctl.merge = instr[17:15];
            ctl.amt   = instr[4:0];
            ctl.emask = instr[9:5];
            ctl.err   = !imm_hit;
        end
    end
endmodule

// File: rtl/shu_rotate.sv
module shu_rotate
    import shu_pkg::*;
(
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amt,
    input  logic          dir,
    output logic [DW-1:0] dout
);
    logic [2*DW-1:0] dbl;
    logic [2*DW-1:0] shl;
    logic [2*DW-1:0] shr;
    logic [AW:0]     left_dist;

    always_comb begin
        dbl       = {din, din};
        left_dist = (AW+1)'(DW) - {1'b0, amt};
        shr       = dbl >> amt;
        shl       = dbl >> left_dist;
        dout      = dir ? shr[DW-1:0] : shl[DW-1:0];
    end
endmodule

// File: rtl/shu_mask.sv
module shu_mask
    import shu_pkg::*;
(
    input  logic [MW-1:0] merge,
    input  logic          dir,
    input  logic          inv,
    input  logic [AW-1:0] amt,
    input  logic [AW-1:0] emask,
    output logic [DW-1:0] cmask,
    output fill_e         fill
);
    smask_e        sm_kind;
    logic [AW-1:0] eff_amt;
    logic [DW-1:0] end_m;
    logic [DW-1:0] shift_m;
    logic [DW-1:0] low_m;

    always_comb begin
        unique case (merge)
            3'd0: begin sm_kind = SM_OFF;  fill = FILL_ZERO;  end
            3'd1: begin sm_kind = SM_OFF;  fill = FILL_MERGE; end
            3'd2: begin sm_kind = SM_OFF;  fill = FILL_SIGN;  end
            3'd3: begin sm_kind = SM_LOW;  fill = FILL_ZERO;  end
            3'd4: begin sm_kind = SM_LOW;  fill = FILL_MERGE; end
            3'd5: begin sm_kind = SM_LOW;  fill = FILL_SIGN;  end
            3'd6: begin sm_kind = SM_HIGH; fill = FILL_ZERO;  end
            3'd7: begin sm_kind = SM_HIGH; fill = FILL_MERGE; end
        endcase
    end

    always_comb begin
        eff_amt = dir ? (AW)'(-amt) : amt;
        low_m   = low_ones(eff_amt);
        end_m   = (emask == '0) ? '1 : low_ones(emask);
        if (inv) end_m = ~end_m;
        unique case (sm_kind)
            SM_OFF:  shift_m = '1;
            SM_LOW:  shift_m = low_m;
            SM_HIGH: shift_m = ~low_m;
            default: shift_m = '1;
        endcase
        cmask = shift_m & end_m;
    end
endmodule

// File: rtl/shu_fill.sv
module shu_fill
    import shu_pkg::*;
(
    input  logic [DW-1:0] rot,
    input  logic [DW-1:0] cmask,
    input  logic [DW-1:0] old_dest,
    input  fill_e         fill,
    output logic [DW-1:0] res
);
    logic [DW-1:0] zero_v;
    logic [DW-1:0] merge_v;
    logic [DW-1:0] sign_v;

    assign zero_v  = rot & cmask;
    assign merge_v = (rot & cmask) | (old_dest & ~cmask);
    assign sign_v[0] = rot[0] & cmask[0];

    for (genvar b = 1; b < DW; b++) begin : g_chain
        assign sign_v[b] = cmask[b] ? rot[b] : sign_v[b-1];
    end

    always_comb begin
        unique case (fill)
            FILL_ZERO:  res = zero_v;
            FILL_MERGE: res = merge_v;
            FILL_SIGN:  res = sign_v;
            default:    res = zero_v;
        endcase
    end
endmodule

// File: rtl/shu_top.sv
module shu_top
    import shu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   instr,
    input  logic [31:0]   src_val,
    input  logic [31:0]   pair_val,
    input  logic [31:0]   rot_reg_val,
    input  logic [31:0]   dest_val,
    output logic          out_valid,
    output logic [31:0]   out_result,
    output logic [4:0]    out_dest,
    output logic          out_err
);
    ctl_t          ctl;
    logic [DW-1:0] rot_v;
    logic [DW-1:0] cmask;
    fill_e         fill;
    logic [DW-1:0] fill_res;
    logic [DW-1:0] res_next;
    ostate_e       state_q;
    ostate_e       state_d;

    shu_decode u_dec (
        .instr       (instr),
        .rot_reg_val (rot_reg_val),
        .pair_val    (pair_val),
        .ctl         (ctl)
    );

    shu_rotate u_rot (
        .din  (src_val),
        .amt  (ctl.amt),
        .dir  (ctl.dir),
        .dout (rot_v)
    );

    shu_mask u_msk (
        .merge (ctl.merge),
        .dir   (ctl.dir),
        .inv   (ctl.inv),
        .amt   (ctl.amt),
        .emask (ctl.emask),
        .cmask (cmask),
        .fill  (fill)
    );

    shu_fill u_fil (
        .rot      (rot_v),
        .cmask    (cmask),
        .old_dest (dest_val),
        .fill     (fill),
        .res      (fill_res)
    );

    assign res_next = ctl.err ? '0 : fill_res;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_dest   <= '0;
            out_err    <= 1'b0;
        end else if (in_valid) begin
            out_result <= res_next;
            out_dest   <= ctl.dest;
            out_err    <= ctl.err;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_result == '0));

    // R11
    odd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[21:16] == 6'b110001 && instr[9:5] != '0 && instr[22])
        |=> out_err);

    // R12
    dest_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dest == $past(instr[31:27])));

    // R6
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[21:18] == 4'b0001 && instr[17:15] == 3'd0 && instr[11:0] == '0)
        |=> (out_result == $past(src_val)));
endmodule

// File: tb/tb_shu_top.sv
`timescale 1ns/1ps
module tb_shu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, src_val, pair_val, rot_reg_val, dest_val;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_dest;
    logic        out_err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .pair_val(pair_val), .rot_reg_val(rot_reg_val),
        .dest_val(dest_val), .out_valid(out_valid), .out_result(out_result),
        .out_dest(out_dest), .out_err(out_err)
    );

    function automatic logic [31:0] mk_imm(input logic [4:0] d, input logic [4:0] s,
        input logic [2:0] m, input logic i, input logic n, input logic [4:0] em,
        input logic [4:0] r);
        return {d, s, 4'b0001, m, 3'b000, i, n, em, r};
    endfunction

    function automatic logic [31:0] mk_reg(input logic [4:0] d, input logic [4:0] s,
        input logic [2:0] m, input logic i, input logic n, input logic [4:0] em,
        input logic [4:0] r);
        return {d, s, 6'b110001, m, 1'b0, i, n, em, r};
    endfunction

    // row: instr, src, dest, rot reg, pair, expected result, expected err
    localparam int NV = 18;
    localparam logic [192:0] TBL [NV] = '{
        {mk_imm(5'd1, 5'd2, 3'd0, 1'b0, 1'b0, 5'd0, 5'd4),  32'h12345678, 32'h0, 32'h0, 32'h0, 32'h23456781, 1'b0}, // R3 left
        {mk_imm(5'd2, 5'd2, 3'd0, 1'b0, 1'b1, 5'd0, 5'd8),  32'h12345678, 32'h0, 32'h0, 32'h0, 32'h78123456, 1'b0}, // R3 right
        {mk_imm(5'd3, 5'd2, 3'd6, 1'b0, 1'b0, 5'd0, 5'd4),  32'h12345678, 32'h0, 32'h0, 32'h0, 32'h23456780, 1'b0}, // R5 R6 left shift
        {mk_imm(5'd4, 5'd2, 3'd3, 1'b0, 1'b1, 5'd0, 5'd8),  32'h12345678, 32'h0, 32'h0, 32'h0, 32'h00123456, 1'b0}, // R5 right logical
        {mk_imm(5'd5, 5'd2, 3'd5, 1'b0, 1'b1, 5'd0, 5'd8),  32'h87654321, 32'h0, 32'h0, 32'h0, 32'hFF876543, 1'b0}, // R8 arith
        {mk_imm(5'd6, 5'd2, 3'd4, 1'b0, 1'b1, 5'd0, 5'd8),  32'h12345678, 32'hAABBCCDD, 32'h0, 32'h0, 32'hAA123456, 1'b0}, // R7
        {mk_imm(5'd7, 5'd2, 3'd7, 1'b0, 1'b0, 5'd0, 5'd4),  32'h12345678, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h2345678F, 1'b0}, // R7
        {mk_imm(5'd8, 5'd2, 3'd0, 1'b0, 1'b0, 5'd8, 5'd0),  32'hDEADBEEF, 32'h0, 32'h0, 32'h0, 32'h000000EF, 1'b0}, // R4
        {mk_imm(5'd9, 5'd2, 3'd0, 1'b1, 1'b0, 5'd8, 5'd0),  32'hDEADBEEF, 32'h0, 32'h0, 32'h0, 32'hDEADBE00, 1'b0}, // R4 invert
        {mk_imm(5'd10, 5'd2, 3'd2, 1'b0, 1'b0, 5'd8, 5'd0), 32'h00000080, 32'h0, 32'h0, 32'h0, 32'hFFFFFF80, 1'b0}, // R8
        {mk_imm(5'd11, 5'd2, 3'd3, 1'b0, 1'b1, 5'd0, 5'd0), 32'hCAFEF00D, 32'h0, 32'h0, 32'h0, 32'h00000000, 1'b0}, // R5 zero amt
        {mk_imm(5'd12, 5'd2, 3'd6, 1'b0, 1'b1, 5'd0, 5'd0), 32'hCAFEF00D, 32'h0, 32'h0, 32'h0, 32'hCAFEF00D, 1'b0}, // R5 zero amt inv
        {mk_reg(5'd13, 5'd2, 3'd0, 1'b0, 1'b0, 5'd0, 5'd7), 32'h12345678, 32'h0, 32'h00000024, 32'h0, 32'h23456781, 1'b0}, // R10 R9
        {mk_reg(5'd14, 5'd2, 3'd0, 1'b0, 1'b0, 5'd1, 5'd7), 32'hDEADBEEF, 32'h0, 32'h0, 32'h00000108, 32'h000000EF, 1'b0}, // R10
        {mk_reg(5'd15, 5'd3, 3'd0, 1'b0, 1'b0, 5'd1, 5'd7), 32'hDEADBEEF, 32'h0, 32'h0, 32'h00000008, 32'h00000000, 1'b1}, // R11 odd
        {32'h00000000,                                      32'hDEADBEEF, 32'h0, 32'h0, 32'h0, 32'h00000000, 1'b1}, // R11 bad op
        {mk_imm(5'd16, 5'd2, 3'd2, 1'b1, 1'b0, 5'd1, 5'd0), 32'h00000003, 32'h0, 32'h0, 32'h0, 32'h00000002, 1'b0}, // R8 bit0
        {mk_reg(5'd17, 5'd2, 3'd4, 1'b0, 1'b1, 5'd0, 5'd9), 32'h12345678, 32'hAABBCCDD, 32'h00000008, 32'h0, 32'hAA123456, 1'b0}  // R9 reg merge field
    };

    function automatic logic [31:0] ref_model(input logic [31:0] w, input logic [31:0] s,
        input logic [31:0] d, input logic [31:0] rr, input logic [31:0] pr, output logic e);
        logic [31:0] r, em, sm, cm, res;
        int amt, ecnt, eff, mg;
        bit isreg, isimm;
        isimm = (w[21:18] == 4'b0001);
        isreg = (w[21:16] == 6'b110001);
        e = !(isimm || isreg) || (isreg && w[9:5] != 0 && w[22]);
        if (e) return 32'h0;
        mg   = isreg ? int'(w[15:13]) : int'(w[17:15]);
        amt  = isreg ? int'(rr[4:0]) : int'(w[4:0]);
        ecnt = isreg ? ((w[9:5] == 0) ? 0 : int'(pr[4:0])) : int'(w[9:5]);
        for (int b = 0; b < 32; b++)
            r[b] = w[10] ? s[(b + amt) % 32] : s[(b - amt + 32) % 32];
        eff = w[10] ? (32 - amt) % 32 : amt;
        for (int b = 0; b < 32; b++) begin
            em[b] = (ecnt == 0) ? 1'b1 : (b < ecnt);
            if (w[11]) em[b] = !em[b];
            if (mg < 3) sm[b] = 1'b1;
            else if (mg < 6) sm[b] = (b < eff);
            else sm[b] = !(b < eff);
        end
        cm = sm & em;
        res = r & cm;
        if (mg == 1 || mg == 4 || mg == 7) res = res | (d & ~cm);
        if (mg == 2 || mg == 5)
            for (int b = 1; b < 32; b++) if (!cm[b]) res[b] = res[b-1];
        return res;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic [31:0] s, input logic [31:0] d,
        input logic [31:0] rr, input logic [31:0] pr);
        instr = w; src_val = s; dest_val = d; rot_reg_val = rr; pair_val = pr;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_r, prev_r, w, s, d;
        logic        exp_e, prev_e;
        logic [4:0]  prev_d;
        rst = 1'b1; in_valid = 1'b0;
        instr = '0; src_val = '0; pair_val = '0; rot_reg_val = '0; dest_val = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, out_valid}, 32'h0);
        chk("R1 result", out_result, 32'h0);
        chk("R1 err", {31'b0, out_err}, 32'h0);
        chk("R1 dest", {27'b0, out_dest}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {31'b0, out_valid}, 32'h0);

        // table walked back to back: every row after the first meets T_RELOAD
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k][192:161], TBL[k][160:129], TBL[k][128:97], TBL[k][96:65], TBL[k][64:33]);
            @(negedge clk);
            chk("R2 valid", {31'b0, out_valid}, 32'h1);
            chk("R3-R11 result", out_result, TBL[k][32:1]);
            chk("R11 err", {31'b0, out_err}, {31'b0, TBL[k][0]});
            chk("R12 dest", {27'b0, out_dest}, {27'b0, TBL[k][192:188]});
        end
        in_valid = 1'b0;
        prev_r = out_result;
        @(negedge clk);
        chk("R2 drop", {31'b0, out_valid}, 32'h0);
        chk("R2 hold", out_result, prev_r);

        // random immediate-form words against the reference model (R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 400; k++) begin
            w = mk_imm(5'($urandom), 5'($urandom), 3'(k % 8), 1'((k / 8) % 2),
                       1'((k / 16) % 2), 5'($urandom), 5'($urandom));
            if (k % 5 == 0) w[9:5] = 5'd0;
            s = $urandom; d = $urandom;
            exp_r = ref_model(w, s, d, 32'h0, 32'h0, exp_e);
            drive(w, s, d, 32'h0, 32'h0);
            @(negedge clk);
            chk("R6 random", out_result, exp_r);
        end

        // random register-form words (R10 R11)
        for (int k = 0; k < 100; k++) begin
            w = mk_reg(5'($urandom), 5'($urandom), 3'($urandom), 1'($urandom),
                       1'($urandom), 5'($urandom), 5'($urandom));
            s = $urandom; d = $urandom;
            prev_r = $urandom; exp_r = $urandom;
            exp_r = ref_model(w, s, d, prev_r, exp_r, exp_e);
            drive(w, s, d, prev_r, rot_reg_val);
            pair_val = $urandom;
            exp_r = ref_model(w, s, d, prev_r, pair_val, exp_e);
            @(negedge clk);
            chk("R10 random result", out_result, exp_r);
            chk("R11 random err", {31'b0, out_err}, {31'b0, exp_e});
        end

        // reset mid-stream clears the outputs (R1)
        in_valid = 1'b0;
        prev_e = out_err; prev_d = out_dest;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset valid", {31'b0, out_valid}, 32'h0);
        chk("R1 mid reset result", out_result, 32'h0);
        chk("R1 mid reset dest", {27'b0, out_dest}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule